// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Empty and Almost-Full Flags

This block is a first-in first-out buffer that links two unrelated clock domains. A producer writes words on the write clock, and a consumer reads them on the read clock. Both sides use active-low enables. Each side keeps its own binary pointers. Each pointer crosses to the other domain as a Gray code through a two-flop synchroniser, and the full, empty and programmable level flags are derived from those pointers. The almost-empty flag is registered only on the read clock and the almost-full flag only on the write clock. Both flags are active low.

While reset is held, an input picks one of two read behaviours. In standard mode a word appears on the output one read-clock edge after a read request. In fall-through mode the oldest word moves into the output register without any read request, and a read request retires it. That output register adds one word of capacity. Both flag thresholds therefore shift up by one in fall-through mode.

The read side runs a small state machine with three states:
- `RS_STD` is used for standard mode and stays there.
- `RS_HOLE` means fall-through mode with the output register invalid.
- `RS_READY` means fall-through mode with a valid word at the output.

The transitions are:
- `RS_HOLE` goes to `RS_READY` when memory holds a word (fetch).
- `RS_READY` stays in `RS_READY` when a read retires the word and another is fetched, or when no read is requested.
- `RS_READY` goes to `RS_HOLE` when a read retires the last word.

Reset enters `RS_STD` or `RS_HOLE` according to the mode input.

Top module: `dcfifo_progflag`

## Requirements
- R1: While `rst_n` is low, `ae_n` is 0, `af_n` is 1, `empty` is 1 and `full` is 0.
- R2: `fwft_sel` is sampled only while `rst_n` is low (1 = fall-through, 0 = standard); changing it afterwards has no effect. In fall-through mode the first word written reaches `dout` and clears `empty` with no read request.
- R3: Words leave in the order they were written. In standard mode `dout` updates on the read-clock edge that accepts a read. In fall-through mode `dout` holds the oldest word until a read retires it.
- R4: A write while `full` is 1 is ignored and stores nothing.
- R5: A read while `empty` is 1 is ignored and does not advance the read pointer.
- R6: In standard mode, with n = `AE_OFS`, `ae_n` is 0 while the stored count is n or fewer and 1 from n+1 upward.
- R7: In fall-through mode `ae_n` is 0 while the count (output register included) is n+1 or fewer and 1 from n+2 upward.
- R8: With m = `AF_OFS` and D = `DEPTH` (standard) or `DEPTH`+1 (fall-through), `af_n` is 0 while the count is D−m or more and 1 at D−(m+1) or fewer.
- R9: `ae_n` changes only on read-clock edges and `af_n` only on write-clock edges. A local operation updates the flag on the same edge. A change from the other side may arrive a few cycles late.
- R10: `full` is 1 when memory holds `DEPTH` words, so the count is `DEPTH` in standard mode and `DEPTH`+1 in fall-through mode. `empty` is 1 exactly when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_sel | input | 1 | Mode select, sampled during reset: 1 fall-through, 0 standard |
| wr_en_n | input | 1 | Active-low write request (write clock) |
| din | input | WIDTH | Write data |
| rd_en_n | input | 1 | Active-low read request (read clock) |
| dout | output | WIDTH | Read data register |
| full | output | 1 | Memory full (write clock) |
| empty | output | 1 | No word available (read clock) |
| ae_n | output | 1 | Active-low programmable almost-empty (read clock) |
| af_n | output | 1 | Active-low programmable almost-full (write clock) |

## Verification
The bench builds the block with a depth of 16, an almost-empty offset of 3 and an almost-full offset of 2. With these values a full fill-and-drain sweep of every occupancy level in both modes stays short. The sweep crosses both flag thresholds, the full and empty boundaries and the extra fall-through word. At every step the expected flag levels are computed from the word count. Flags are checked once on the very edge of a local operation and again after the cross-domain pointers have settled.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    // Read-side output stage states
    typedef enum logic [1:0] {
        RS_STD   = 2'd0,   // standard mode: data registered on read
        RS_HOLE  = 2'd1,   // fall-through, output register invalid
        RS_READY = 2'd2    // fall-through, output register valid
    } rd_state_e;

endpackage

// File: rtl/dcfifo_ptr_sync.sv
module dcfifo_ptr_sync #(
    parameter int W = 9
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_bin,
    output logic [W-1:0] dst_bin
);

    logic [W-1:0] src_gray;
    logic [W-1:0] meta_q;
    logic [W-1:0] stage_q;

    // Gray encode in the source domain so only one bit moves per step
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) src_gray <= '0;
        else        src_gray <= src_bin ^ (src_bin >> 1);
    end

    // Two-flop capture in the destination domain
    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= '0;
            stage_q <= '0;
        end else begin
            meta_q  <= src_gray;
            stage_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the parity of all higher gray bits
    for (genvar i = 0; i < W; i++) begin : g_dec
        assign dst_bin[i] = ^stage_q[W-1:i];
    end

endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl #(
    parameter int DEPTH  = 256,
    parameter int AF_OFS = 8,
    parameter int PTR_W  = $clog2(DEPTH) + 1
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             fwft_sel,
    input  logic             wr_en_n,
    input  logic [PTR_W-1:0] fetch_sync,
    input  logic [PTR_W-1:0] consume_sync,
    output logic [PTR_W-1:0] wptr,
    output logic             wr_go,
    output logic             full,
    output logic             af_n
);

    localparam logic [PTR_W-1:0] CAP     = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] AF_BASE = PTR_W'(DEPTH - AF_OFS);

    logic             mode_q;
    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] wptr_nx;
    logic [PTR_W-1:0] fill_mem;
    logic [PTR_W-1:0] fill_all_nx;
    logic [PTR_W-1:0] af_lim;
    logic             af_n_q;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= fwft_sel;
            wptr_q <= '0;
            af_n_q <= 1'b1;
        end else begin
            wptr_q <= wptr_nx;
            af_n_q <= !(fill_all_nx >= af_lim);
        end
    end

    always_comb begin
        fill_mem    = wptr_q - fetch_sync;
        full        = rst_n && (fill_mem == CAP);
        wr_go       = rst_n && !wr_en_n && (fill_mem != CAP);
        wptr_nx     = wptr_q + PTR_W'(wr_go);
        fill_all_nx = wptr_nx - consume_sync;
        af_lim      = AF_BASE + PTR_W'(mode_q);
    end

    assign wptr = wptr_q;
    assign af_n = af_n_q;

    // R1: reset values on the write side
    a_r1_wr_reset: assert property (@(posedge wclk) !rst_n |-> (af_n && !full))
        else $error("R1: write-side flags wrong during reset");

    // R4: a write request while full leaves the pointer unchanged
    a_r4_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && !wr_en_n) |=> (wptr_q == $past(wptr_q)))
        else $error("R4: write pointer moved while full");

    // R10: memory occupancy seen by the writer never exceeds the capacity
    a_r10_mem_bound: assert property (@(posedge wclk) disable iff (!rst_n)
        (wptr_q - fetch_sync) <= CAP)
        else $error("R10: memory occupancy above capacity");

    // R2: latched mode is constant outside reset
    a_r2_wr_mode_hold: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q))
        else $error("R2: write-side mode changed after reset");

endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int WIDTH  = 18,
    parameter int DEPTH  = 256,
    parameter int AE_OFS = 8,
    parameter int PTR_W  = $clog2(DEPTH) + 1
) (
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             fwft_sel,
    input  logic             rd_en_n,
    input  logic [PTR_W-1:0] wptr_sync,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [PTR_W-1:0] fetch_ptr,
    output logic [PTR_W-1:0] consume_ptr,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             ae_n
);

    localparam logic [PTR_W-1:0] AE_BASE = PTR_W'(AE_OFS);

    rd_state_e        state_q, state_nx;
    logic [PTR_W-1:0] fetch_q, consume_q;
    logic [PTR_W-1:0] fetch_nx, consume_nx;
    logic [PTR_W-1:0] mem_cnt, cnt_nx, ae_lim;
    logic [WIDTH-1:0] dout_q;
    logic             ae_n_q;
    logic             have, fetch_go, consume_go, load;
    logic             fwft;

    // State and pointer register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= fwft_sel ? RS_HOLE : RS_STD;
            fetch_q   <= '0;
            consume_q <= '0;
            dout_q    <= '0;
            ae_n_q    <= 1'b0;
        end else begin
            state_q   <= state_nx;
            fetch_q   <= fetch_nx;
            consume_q <= consume_nx;
            if (load) dout_q <= mem_rdata;
            ae_n_q    <= !(cnt_nx <= ae_lim);
        end
    end

    // Next state and outputs
    always_comb begin
        mem_cnt    = wptr_sync - fetch_q;
        have       = (mem_cnt != '0);
        fwft       = (state_q != RS_STD);
        state_nx   = state_q;
        fetch_go   = 1'b0;
        consume_go = 1'b0;
        load       = 1'b0;
        empty      = 1'b1;
        unique case (state_q)
            RS_STD: begin
                empty = !have;
                if (!rd_en_n && have) begin
                    fetch_go   = 1'b1;
                    consume_go = 1'b1;
                    load       = 1'b1;
                end
            end
            RS_HOLE: begin
                empty = 1'b1;
                if (have) begin
                    fetch_go = 1'b1;
                    load     = 1'b1;
                    state_nx = RS_READY;
                end
            end
            RS_READY: begin
                empty = 1'b0;
                if (!rd_en_n) begin
                    consume_go = 1'b1;
                    if (have) begin
                        fetch_go = 1'b1;
                        load     = 1'b1;
                    end else begin
                        state_nx = RS_HOLE;
                    end
                end
            end
            default: begin
                state_nx = RS_STD;
            end
        endcase
        fetch_nx   = fetch_q + PTR_W'(fetch_go);
        consume_nx = consume_q + PTR_W'(consume_go);
        cnt_nx     = wptr_sync - consume_nx;
        ae_lim     = AE_BASE + PTR_W'(fwft);
    end

    assign fetch_ptr   = fetch_q;
    assign consume_ptr = consume_q;
    assign dout        = dout_q;
    assign ae_n        = ae_n_q;

    // R1: reset values on the read side
    a_r1_rd_reset: assert property (@(posedge rclk) !rst_n |-> (!ae_n && empty))
        else $error("R1: read-side flags wrong during reset");

    // R5: a standard-mode read with no stored word leaves the pointer alone
    a_r5_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
        (state_q == RS_STD && !rd_en_n && wptr_sync == fetch_q)
        |=> (fetch_q == $past(fetch_q)))
        else $error("R5: read pointer moved while empty");

    // R3: a presented fall-through word stays until it is read
    a_r3_fwft_hold: assert property (@(posedge rclk) disable iff (!rst_n)
        (state_q == RS_READY && rd_en_n)
        |=> (state_q == RS_READY && $stable(dout_q)))
        else $error("R3: fall-through output changed without a read");

    // R2: the chosen mode never changes outside reset
    a_r2_rd_mode_hold: assert property (@(posedge rclk) disable iff (!rst_n)
        (state_q == RS_STD) |=> (state_q == RS_STD))
        else $error("R2: read side left standard mode");

endmodule

// File: rtl/dcfifo_progflag.sv
module dcfifo_progflag #(
    parameter int WIDTH  = 18,
    parameter int DEPTH  = 256,
    parameter int AE_OFS = 8,
    parameter int AF_OFS = 8
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             fwft_sel,
    input  logic             wr_en_n,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_en_n,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic             ae_n,
    output logic             af_n
);

    localparam int AW    = $clog2(DEPTH);
    localparam int PTR_W = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, wptr_rs;
    logic [PTR_W-1:0] fetch_ptr, fetch_ws;
    logic [PTR_W-1:0] consume_ptr, consume_ws;
    logic [WIDTH-1:0] mem_rdata;
    logic             wr_go;

    always_ff @(posedge wclk) begin
        if (wr_go) mem[wptr[AW-1:0]] <= din;
    end

    assign mem_rdata = mem[fetch_ptr[AW-1:0]];

    dcfifo_wr_ctl #(
        .DEPTH (DEPTH),
        .AF_OFS(AF_OFS),
        .PTR_W (PTR_W)
    ) wr_ctl_i (
        .wclk        (wclk),
        .rst_n       (rst_n),
        .fwft_sel    (fwft_sel),
        .wr_en_n     (wr_en_n),
        .fetch_sync  (fetch_ws),
        .consume_sync(consume_ws),
        .wptr        (wptr),
        .wr_go       (wr_go),
        .full        (full),
        .af_n        (af_n)
    );

    dcfifo_rd_ctl #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .AE_OFS(AE_OFS),
        .PTR_W (PTR_W)
    ) rd_ctl_i (
        .rclk       (rclk),
        .rst_n      (rst_n),
        .fwft_sel   (fwft_sel),
        .rd_en_n    (rd_en_n),
        .wptr_sync  (wptr_rs),
        .mem_rdata  (mem_rdata),
        .fetch_ptr  (fetch_ptr),
        .consume_ptr(consume_ptr),
        .dout       (dout),
        .empty      (empty),
        .ae_n       (ae_n)
    );

    dcfifo_ptr_sync #(.W(PTR_W)) wsync_i (
        .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n),
        .src_bin(wptr), .dst_bin(wptr_rs)
    );

    dcfifo_ptr_sync #(.W(PTR_W)) fsync_i (
        .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n),
        .src_bin(fetch_ptr), .dst_bin(fetch_ws)
    );

    dcfifo_ptr_sync #(.W(PTR_W)) csync_i (
        .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n),
        .src_bin(consume_ptr), .dst_bin(consume_ws)
    );

endmodule

// File: tb/dcfifo_progflag_tb.sv
module dcfifo_progflag_tb_top;

    localparam int WIDTH  = 18;
    localparam int DEPTH  = 16;
    localparam int AE_OFS = 3;
    localparam int AF_OFS = 2;
    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;

    logic             wclk = 1'b0;
    logic             rclk = 1'b0;
    logic             rst_n = 1'b1;
    logic             fwft_sel = 1'b0;
    logic             wr_en_n = 1'b1;
    logic [WIDTH-1:0] din = '0;
    logic             rd_en_n = 1'b1;
    logic [WIDTH-1:0] dout;
    logic             full, empty, ae_n, af_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(WCLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    dcfifo_progflag #(
        .WIDTH(WIDTH), .DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)
    ) dut_i (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
        .wr_en_n(wr_en_n), .din(din), .rd_en_n(rd_en_n), .dout(dout),
        .full(full), .empty(empty), .ae_n(ae_n), .af_n(af_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] val(input int k, input bit f);
        return WIDTH'(k * 1031 + (f ? 7 : 0) + 5);
    endfunction

    function automatic logic exp_ae_n(input int cnt, input bit f);
        return !(cnt <= AE_OFS + (f ? 1 : 0));
    endfunction

    function automatic logic exp_af_n(input int cnt, input bit f);
        return !(cnt >= DEPTH + (f ? 1 : 0) - AF_OFS);
    endfunction

    task automatic settle();
        repeat (10) @(negedge rclk);
    endtask

    task automatic push(input logic [WIDTH-1:0] v);
        @(negedge wclk);
        wr_en_n = 1'b0;
        din     = v;
        @(negedge wclk);
        wr_en_n = 1'b1;
    endtask

    task automatic pop();
        @(negedge rclk);
        rd_en_n = 1'b0;
        @(negedge rclk);
        rd_en_n = 1'b1;
    endtask

    task automatic run_mode(input bit f);
        string aereq;
        int    cap;
        aereq = f ? "R7" : "R6";
        cap   = DEPTH + (f ? 1 : 0);
        wr_en_n  = 1'b1;
        rd_en_n  = 1'b1;
        fwft_sel = f;
        @(negedge wclk);
        rst_n = 1'b0;
        repeat (3) @(negedge wclk);
        // R1: values while reset is held
        check("R1", "ae_n in reset", 32'(ae_n), 32'(1'b0));
        check("R1", "af_n in reset", 32'(af_n), 32'(1'b1));
        check("R1", "empty in reset", 32'(empty), 32'(1'b1));
        check("R1", "full in reset", 32'(full), 32'(1'b0));
        rst_n = 1'b1;
        // R2: mode input is ignored after reset
        fwft_sel = !f;
        settle();

        // Fill sweep
        for (int k = 1; k <= cap; k++) begin
            push(val(k, f));
            // R9: local write updates af_n on the same write edge (R8 level)
            check("R9", "af_n right after write", 32'(af_n), 32'(exp_af_n(k, f)));
            settle();
            check(aereq, "ae_n after fill step", 32'(ae_n), 32'(exp_ae_n(k, f)));
            check("R10", "full after fill step", 32'(full), 32'(k >= cap));
            check("R10", "empty after fill step", 32'(empty), 32'(1'b0));
            if (f && k == 1) begin
                check("R2", "fall-through first word on dout", 32'(dout), 32'(val(1, f)));
            end
        end

        // R4: extra write while full
        push(val(99, f));
        settle();
        check("R4", "full held after ignored write", 32'(full), 32'(1'b1));
        check("R8", "af_n low at capacity", 32'(af_n), 32'(1'b0));

        // Drain sweep
        for (int k = cap; k >= 1; k--) begin
            int idx;
            idx = cap - k + 1;
            if (f) check("R3", "fall-through head before read", 32'(dout), 32'(val(idx, f)));
            pop();
            if (!f) check("R3", "standard data after read", 32'(dout), 32'(val(idx, f)));
            // R9: local read updates ae_n on the same read edge
            check("R9", "ae_n right after read", 32'(ae_n), 32'(exp_ae_n(k - 1, f)));
            settle();
            check("R8", "af_n after drain step", 32'(af_n), 32'(exp_af_n(k - 1, f)));
            check("R10", "full after drain step", 32'(full), 32'(1'b0));
            check("R10", "empty after drain step", 32'(empty), 32'(k == 1));
        end

        // R5: read while empty
        pop();
        settle();
        check("R5", "empty held after ignored read", 32'(empty), 32'(1'b1));
        check("R5", "ae_n after ignored read", 32'(ae_n), 32'(1'b0));
        push(val(77, f));
        settle();
        check("R5", "empty clears after later write", 32'(empty), 32'(1'b0));
        if (f) begin
            check("R5", "fall-through word after empty read", 32'(dout), 32'(val(77, f)));
            pop();
        end else begin
            pop();
            check("R5", "standard word after empty read", 32'(dout), 32'(val(77, f)));
        end
        settle();
        check("R10", "empty at end of mode run", 32'(empty), 32'(1'b1));
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(WCLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule